// File: doc/BRIEF.md
# Counting Bloom Line Lock

This block records which cache lines are owned by descriptors that have passed the hit/miss stage and not yet finished. Each line is named by a key made of a way number and a line index. When a descriptor leaves detection, its key is inserted. When the descriptor completes in the read or write unit, the same key is removed. A combinational probe port answers whether a candidate key may be locked. A caller that gets a positive answer holds its descriptor until the answer turns negative.

The record is an array of small saturating-free counters. Each key passes through several XOR-fold hash functions, and each one picks a counter. An insert raises the picked counters by one and a remove lowers them by one. A probe is positive only when every picked counter is nonzero. A key that is held therefore always probes positive. Keys that were never inserted may also probe positive through shared counters, which only costs stall cycles. The array size comes from parameters and does not depend on the cache size. The counters are wide enough for the largest number of descriptors that can be downstream at once.

Top module: `line_lock_bloom`

## Requirements
- R1: After reset, `empty_o` is 1 and the probe answers 0 for every key.
- R2: In the first cycle after an insert of a key (with no remove in that cycle), probing that key answers 1.
- R3: While several distinct keys are held, each one probes 1, including after other held keys have been removed.
- R4: A key inserted N times keeps probing 1 until it has been removed N times.
- R5: Once every inserted key has been removed, `empty_o` is 1 and the probe answers 0 for every key.
- R6: An insert and a remove may be given in the same cycle and both take effect. When both carry the same key, the counters are unchanged.
- R7: `empty_o` is 0 while at least one key is held.
- R8: Up to `MAX_INFLIGHT` concurrent holds of one key are counted without overflow, and a counter never steps below zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ins_valid_i | input | 1 | Insert the key on ins_way_i/ins_idx_i this cycle |
| ins_way_i | input | WAY_W | Way number of the inserted line |
| ins_idx_i | input | IDX_W | Line index of the inserted line |
| rem_valid_i | input | 1 | Remove the key on rem_way_i/rem_idx_i this cycle |
| rem_way_i | input | WAY_W | Way number of the released line |
| rem_idx_i | input | IDX_W | Line index of the released line |
| probe_way_i | input | WAY_W | Way number of the candidate line |
| probe_idx_i | input | IDX_W | Line index of the candidate line |
| probe_hit_o | output | 1 | 1 when the candidate line may be locked |
| empty_o | output | 1 | 1 when no counter is nonzero |

## Verification
An insert and a remove can land on the same clock edge. The bench provokes this both with different keys, where one key is handed over to another, and with one key on both ports, which must leave the state as it was. The result is judged at the ports. The newly inserted key must probe 1, and after that key is removed the filter must read empty. In the same-key case, a key held before must still probe 1, and releasing that key must bring `empty_o` back.

// File: rtl/line_lock_bloom.sv
module line_lock_bloom #(
  parameter int unsigned WAY_W        = 2,
  parameter int unsigned IDX_W        = 6,
  parameter int unsigned NUM_HASH     = 3,
  parameter int unsigned NUM_CNT      = 32,
  parameter int unsigned MAX_INFLIGHT = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ins_valid_i,
  input  logic [WAY_W-1:0] ins_way_i,
  input  logic [IDX_W-1:0] ins_idx_i,
  input  logic             rem_valid_i,
  input  logic [WAY_W-1:0] rem_way_i,
  input  logic [IDX_W-1:0] rem_idx_i,
  input  logic [WAY_W-1:0] probe_way_i,
  input  logic [IDX_W-1:0] probe_idx_i,
  output logic             probe_hit_o,
  output logic             empty_o
);

  localparam int unsigned KEY_W  = WAY_W + IDX_W;
  localparam int unsigned HASH_W = $clog2(NUM_CNT);
  localparam int unsigned CNT_W  = $clog2(MAX_INFLIGHT + 1);

  function automatic logic [HASH_W-1:0] fold(input logic [KEY_W-1:0] key, input int seed);
    logic [HASH_W-1:0] r;
    r = HASH_W'(seed * 5 + 1);
    for (int i = 0; i < KEY_W; i++)
      r[(i + seed * (i / HASH_W + 1)) % HASH_W] ^= key[i];
    return r;
  endfunction

  function automatic logic [NUM_CNT-1:0] pick(input logic [KEY_W-1:0] key);
    logic [NUM_CNT-1:0] m;
    m = '0;
    for (int k = 0; k < NUM_HASH; k++)
      m[fold(key, k)] = 1'b1;
    return m;
  endfunction

  logic [KEY_W-1:0] ins_key, rem_key, probe_key;
  logic [NUM_CNT-1:0] inc_mask, dec_mask, nz;
  logic [NUM_CNT-1:0][CNT_W-1:0] cnt_q;

  assign ins_key   = {ins_way_i, ins_idx_i};
  assign rem_key   = {rem_way_i, rem_idx_i};
  assign probe_key = {probe_way_i, probe_idx_i};
  assign inc_mask  = ins_valid_i ? pick(ins_key) : '0;
  assign dec_mask  = rem_valid_i ? pick(rem_key) : '0;

  for (genvar j = 0; j < NUM_CNT; j++) begin : g_cnt
    assign nz[j] = cnt_q[j] != '0;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        cnt_q[j] <= '0;
      else if (inc_mask[j] && !dec_mask[j])
        cnt_q[j] <= cnt_q[j] + CNT_W'(1);
      else if (dec_mask[j] && !inc_mask[j])
        cnt_q[j] <= cnt_q[j] - CNT_W'(1);
    end
  end

  assign probe_hit_o = (pick(probe_key) & ~nz) == '0;
  assign empty_o     = ~|nz;

endmodule

// File: rtl/line_lock_bloom_chk.sv
module line_lock_bloom_chk #(
  parameter int unsigned KEY_W        = 8,
  parameter int unsigned NUM_CNT      = 32,
  parameter int unsigned CNT_W        = 4,
  parameter int unsigned MAX_INFLIGHT = 12
) (
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic                          ins_valid_i,
  input logic                          rem_valid_i,
  input logic [KEY_W-1:0]              ins_key,
  input logic [KEY_W-1:0]              rem_key,
  input logic [KEY_W-1:0]              probe_key,
  input logic                          probe_hit_o,
  input logic                          empty_o,
  input logic [NUM_CNT-1:0]            inc_mask,
  input logic [NUM_CNT-1:0]            dec_mask,
  input logic [NUM_CNT-1:0][CNT_W-1:0] cnt_q
);

  for (genvar j = 0; j < NUM_CNT; j++) begin : g_chk
    AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (inc_mask[j] && !dec_mask[j]) |-> (cnt_q[j] != CNT_W'(MAX_INFLIGHT))); // R8
    AST_NO_UNDERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (dec_mask[j] && !inc_mask[j]) |-> (cnt_q[j] != '0)); // R8
  end

  AST_INSERT_VISIBLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(ins_valid_i) && !$past(rem_valid_i) && probe_key == $past(ins_key)) |-> probe_hit_o); // R2

  AST_EMPTY_NO_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o |-> !probe_hit_o); // R5

  AST_SAME_KEY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ins_valid_i && rem_valid_i && ins_key == rem_key) |=> $stable(cnt_q)); // R6

  AST_IDLE_EMPTY_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ins_valid_i && !rem_valid_i) |=> $stable(empty_o)); // R7

endmodule

bind line_lock_bloom line_lock_bloom_chk #(
  .KEY_W(KEY_W), .NUM_CNT(NUM_CNT), .CNT_W(CNT_W), .MAX_INFLIGHT(MAX_INFLIGHT)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ins_valid_i(ins_valid_i), .rem_valid_i(rem_valid_i),
  .ins_key(ins_key), .rem_key(rem_key), .probe_key(probe_key),
  .probe_hit_o(probe_hit_o), .empty_o(empty_o),
  .inc_mask(inc_mask), .dec_mask(dec_mask), .cnt_q(cnt_q)
);

// File: tb/line_lock_bloom_tb.sv
module line_lock_bloom_tb;
  localparam int WAY_W = 2;
  localparam int IDX_W = 6;
  localparam int KEY_W = WAY_W + IDX_W;
  localparam int MAXF  = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic iv = 1'b0, rv = 1'b0;
  logic [KEY_W-1:0] ik = '0, rk = '0, pk = '0;
  logic hit, empty;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  line_lock_bloom #(.WAY_W(WAY_W), .IDX_W(IDX_W), .MAX_INFLIGHT(MAXF)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .ins_valid_i(iv), .ins_way_i(ik[KEY_W-1:IDX_W]), .ins_idx_i(ik[IDX_W-1:0]),
    .rem_valid_i(rv), .rem_way_i(rk[KEY_W-1:IDX_W]), .rem_idx_i(rk[IDX_W-1:0]),
    .probe_way_i(pk[KEY_W-1:IDX_W]), .probe_idx_i(pk[IDX_W-1:0]),
    .probe_hit_o(hit), .empty_o(empty)
  );

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic op(input logic di, input logic [KEY_W-1:0] ki,
                    input logic dr, input logic [KEY_W-1:0] kr);
    @(negedge clk);
    iv = di; ik = ki; rv = dr; rk = kr;
    @(negedge clk);
    iv = 1'b0; rv = 1'b0;
  endtask

  task automatic probe(input string req, input logic [KEY_W-1:0] k, input logic exp);
    pk = k;
    #1;
    check(req, hit, exp);
  endtask

  task automatic all_free(input string req);
    check(req, empty, 1'b1);
    for (int k = 0; k < (1 << KEY_W); k++) probe(req, KEY_W'(k), 1'b0);
  endtask

  task automatic t_reset();
    all_free("R1");
  endtask

  task automatic t_single();
    op(1'b1, 8'h5A, 1'b0, '0);
    probe("R2", 8'h5A, 1'b1);
    check("R7", empty, 1'b0);
    op(1'b0, '0, 1'b1, 8'h5A);
    all_free("R5");
  endtask

  task automatic t_multi();
    logic [KEY_W-1:0] keys [5] = '{8'h01, 8'h47, 8'h9C, 8'hE3, 8'h30};
    for (int i = 0; i < 5; i++) op(1'b1, keys[i], 1'b0, '0);
    for (int i = 0; i < 5; i++) probe("R3", keys[i], 1'b1);
    for (int i = 0; i < 5; i++) begin
      op(1'b0, '0, 1'b1, keys[i]);
      for (int j = i + 1; j < 5; j++) probe("R3", keys[j], 1'b1);
      if (i < 4) check("R7", empty, 1'b0);
    end
    all_free("R5");
  endtask

  task automatic t_repeat();
    for (int i = 0; i < MAXF; i++) op(1'b1, 8'hC7, 1'b0, '0);
    probe("R8", 8'hC7, 1'b1);
    for (int i = 0; i < MAXF - 1; i++) begin
      op(1'b0, '0, 1'b1, 8'hC7);
      probe("R4", 8'hC7, 1'b1);
    end
    op(1'b0, '0, 1'b1, 8'hC7);
    all_free("R4");
  endtask

  task automatic t_concurrent();
    op(1'b1, 8'h12, 1'b0, '0);
    op(1'b1, 8'hA9, 1'b1, 8'h12);
    probe("R6", 8'hA9, 1'b1);
    op(1'b1, 8'h3F, 1'b1, 8'h3F);
    probe("R6", 8'hA9, 1'b1);
    op(1'b0, '0, 1'b1, 8'hA9);
    all_free("R6");
    op(1'b1, 8'h77, 1'b1, 8'h77);
    check("R6", empty, 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single();
    t_multi();
    t_repeat();
    t_concurrent();
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 100000 && !done; c++) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule